// File: doc/BRIEF.md
# Lockable Translation Cache with Victim Pointer

This block is a small, fully associative address-translation cache. It holds 8 or 32 entries. Each entry pairs a tag word with a data word. The tag word carries a virtual page tag, a two-bit page-size code and a valid flag. The data word carries a physical page base and twelve attribute bits. A lookup port takes a virtual address. One cycle later it reports whether any valid entry covers that address and, if one does, the translated physical address and that entry's attributes. Each entry uses its own page size to decide which address bits it compares.

Software manages the entries through a narrow register port. A lock register holds two fields. The first is a base index: slots below it are pinned. The second is a victim index: it names the slot that the next load overwrites, and the same slot is shown by the two read-back registers. To load an entry, software stages a tag word and a data word, then writes the load strobe. The victim then advances and wraps back to the base. Software can also flush one address, which removes every unpinned entry that covers it, or flush everything, which also clears the lock fields.

Top module: `tlb_lockable`

## Requirements
- R1: After reset no entry is valid, the lock register reads zero and every lookup misses.
- R2: Write register map: 0 = lock, 1 = staged tag, 2 = staged data, 3 = load strobe, 4 = flush one address, 5 = flush all. A write to the load strobe stores the staged tag (valid forced on) and data into the slot named by the victim field. Register 6 reads back that slot's tag as {vtag[31:12], 9'b0, valid at bit 2, size at bits 1:0}. Register 7 reads back its data word as {pa[31:12], attr[11:0]}.
- R3: After an accepted load the victim index increments. When the incremented value equals the entry count, it becomes the base value instead.
- R4: A load is rejected when the base field is equal to or above the entry count. No entry changes and the victim stays where it was.
- R5: The page-size code in tag bits 1:0 selects the page: 0 = 4 KB, 1 = 64 KB, 2 = 1 MB, 3 = 16 MB. An entry hits when the address lies in [start, start + size), where start is the tag with the in-page bits cleared. The physical address is the data word's page bits joined with the lookup address's in-page bits.
- R6: The lookup result (lk_valid, lk_hit, lk_pa, lk_attr) appears in the cycle after lk_req. lk_valid is high for exactly that one cycle per request.
- R7: When several entries hit, the entry with the lowest index supplies the result.
- R8: A flush of one address invalidates every entry at or above the base whose range contains that address. Pinned entries are left valid.
- R9: A flush of everything invalidates all entries and sets both base and victim to zero.
- R10: The lock register holds the base in bits 14:10 and the victim in bits 8:4. It reads back what was written, keeping only log2(entry count) victim bits. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| lk_valid | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | 32 | Translated physical address |
| lk_attr | output | 12 | Attributes of the hitting entry |

## Verification
The assertions assume at most one register write per cycle. They also assume the reset is released cleanly before any write or lookup. The bench issues every write and every lookup on its own falling-edge slot, so no two register actions share a clock. The bench runs lookups only while no write is pending. Lock values with a base at or above the entry count are written on purpose, so that the rejection path is exercised within those assumptions.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   typedef enum logic [2:0] {
      RA_LOCK     = 3'd0,
      RA_TAG      = 3'd1,
      RA_DATA     = 3'd2,
      RA_LOAD     = 3'd3,
      RA_FLUSH1   = 3'd4,
      RA_FLUSHALL = 3'd5,
      RA_RDTAG    = 3'd6,
      RA_RDDATA   = 3'd7
   } reg_addr_e;

   typedef struct packed {
      logic [19:0] vtag;
      logic [1:0]  pgsz;
   } tag_t;

   function automatic logic [31:0] page_mask(input logic [1:0] sz);
      case (sz)
         2'd0:    page_mask = 32'hFFFF_F000;
         2'd1:    page_mask = 32'hFFFF_0000;
         2'd2:    page_mask = 32'hFFF0_0000;
         default: page_mask = 32'hFF00_0000;
      endcase
   endfunction
endpackage

// File: rtl/tlb_range_match.sv
module tlb_range_match
   import tlb_pkg::*;
(
   input  logic        vld,
   input  tag_t        tag,
   input  logic [31:0] addr,
   output logic        hit
);
   logic [31:0] msk;
   always_comb begin
      msk = page_mask(tag.pgsz);
      hit = vld && (((addr ^ {tag.vtag, 12'h000}) & msk) == 32'h0);
   end
endmodule

// File: rtl/tlb_first_hit.sv
module tlb_first_hit #(
   parameter int N = 32,
   localparam int IW = $clog2(N)
) (
   input  logic [N-1:0]  hits,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      any = |hits;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (hits[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/tlb_lock_ctrl.sv
module tlb_lock_ctrl #(
   parameter int N = 32,
   localparam int IW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lock_wr,
   input  logic [31:0]   wdata,
   input  logic          load_req,
   input  logic          gflush,
   output logic [4:0]    base,
   output logic [IW-1:0] vict,
   output logic          load_ok
);
   logic [IW:0] vict_inc;

   always_comb begin
      load_ok  = load_req && (int'(base) < N);
      vict_inc = {1'b0, vict} + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base <= '0;
         vict <= '0;
      end else if (gflush) begin
         base <= '0;
         vict <= '0;
      end else if (lock_wr) begin
         base <= wdata[14:10];
         vict <= wdata[4 +: IW];
      end else if (load_ok) begin
         if (int'(vict_inc) == N) vict <= base[IW-1:0];
         else                     vict <= vict_inc[IW-1:0];
      end
   end
endmodule

// File: rtl/tlb_lockable.sv
module tlb_lockable
   import tlb_pkg::*;
#(
   parameter int N = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic [2:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   input  logic        lk_req,
   input  logic [31:0] lk_va,
   output logic        lk_valid,
   output logic        lk_hit,
   output logic [31:0] lk_pa,
   output logic [11:0] lk_attr
);
   localparam int IW = $clog2(N);

   generate
      if (!(N == 8 || N == 32)) begin : g_bad_n
         $error("tlb_lockable: N must be 8 or 32");
      end
   endgenerate

   logic [31:0]   tag_stage_q, data_stage_q;
   tag_t          tag_q  [N];
   logic [31:0]   data_q [N];
   logic [N-1:0]  vld_q;
   logic [4:0]    base_q;
   logic [IW-1:0] vict_q;
   logic          load_ok;
   logic [N-1:0]  lk_hits, fl_hits, unpinned;
   logic          any_hit;
   logic [IW-1:0] hit_idx;
   logic          wr_lock, wr_load, wr_fl1, wr_flall;

   always_comb begin
      wr_lock  = reg_wr && (reg_addr == RA_LOCK);
      wr_load  = reg_wr && (reg_addr == RA_LOAD);
      wr_fl1   = reg_wr && (reg_addr == RA_FLUSH1);
      wr_flall = reg_wr && (reg_addr == RA_FLUSHALL);
   end

   tlb_lock_ctrl #(.N(N)) u_lock (
      .clk(clk), .rst_n(rst_n), .lock_wr(wr_lock), .wdata(reg_wdata),
      .load_req(wr_load), .gflush(wr_flall),
      .base(base_q), .vict(vict_q), .load_ok(load_ok)
   );

   for (genvar i = 0; i < N; i++) begin : g_ent
      tlb_range_match u_lk (
         .vld(vld_q[i]), .tag(tag_q[i]), .addr(lk_va), .hit(lk_hits[i])
      );
      tlb_range_match u_fl (
         .vld(vld_q[i]), .tag(tag_q[i]), .addr(reg_wdata), .hit(fl_hits[i])
      );
      assign unpinned[i] = (i >= int'(base_q));
   end

   tlb_first_hit #(.N(N)) u_sel (.hits(lk_hits), .any(any_hit), .idx(hit_idx));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_stage_q  <= '0;
         data_stage_q <= '0;
      end else if (reg_wr && reg_addr == RA_TAG) begin
         tag_stage_q  <= reg_wdata;
      end else if (reg_wr && reg_addr == RA_DATA) begin
         data_stage_q <= reg_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        vld_q <= '0;
      else if (wr_flall) vld_q <= '0;
      else if (load_ok)  vld_q[vict_q] <= 1'b1;
      else if (wr_fl1)   vld_q <= vld_q & ~(fl_hits & unpinned);
   end

   always_ff @(posedge clk) begin
      if (load_ok) begin
         tag_q[vict_q]  <= '{vtag: tag_stage_q[31:12], pgsz: tag_stage_q[1:0]};
         data_q[vict_q] <= data_stage_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lk_valid <= 1'b0;
         lk_hit   <= 1'b0;
         lk_pa    <= '0;
         lk_attr  <= '0;
      end else begin
         lk_valid <= lk_req;
         if (lk_req) begin
            lk_hit  <= any_hit;
            lk_pa   <= any_hit ?
                       ((data_q[hit_idx] & page_mask(tag_q[hit_idx].pgsz)) |
                        (lk_va & ~page_mask(tag_q[hit_idx].pgsz))) : 32'h0;
            lk_attr <= any_hit ? data_q[hit_idx][11:0] : 12'h0;
         end
      end
   end

   always_comb begin
      case (reg_addr)
         RA_LOCK:   reg_rdata = {17'h0, base_q, 1'b0, 5'(vict_q), 4'h0};
         RA_TAG:    reg_rdata = tag_stage_q;
         RA_DATA:   reg_rdata = data_stage_q;
         RA_RDTAG:  reg_rdata = {tag_q[vict_q].vtag, 9'h0, vld_q[vict_q],
                                 tag_q[vict_q].pgsz};
         RA_RDDATA: reg_rdata = data_q[vict_q];
         default:   reg_rdata = 32'h0;
      endcase
   end
endmodule

// File: rtl/tlb_lockable_chk.sv
module tlb_lockable_chk #(
   parameter int N = 32,
   localparam int IW = $clog2(N)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          reg_wr,
   input logic [2:0]    reg_addr,
   input logic          lk_req,
   input logic          lk_valid,
   input logic          lk_hit,
   input logic [N-1:0]  vld_q,
   input logic [4:0]    base_q,
   input logic [IW-1:0] vict_q
);
   // R6: result valid exactly one cycle after each request
   a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req |=> lk_valid);
   a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_req |=> !lk_valid);

   // R1: nothing valid means a miss
   a_r1_empty_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_req && vld_q == '0 && !reg_wr) |=> !lk_hit);

   // R9: global flush clears all state
   a_r9_gflush: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 3'd5) |=> (vld_q == '0 && base_q == '0 && vict_q == '0));

   // R4: rejected load changes nothing
   a_r4_reject: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 3'd3 && int'(base_q) >= N) |=> ($stable(vld_q) && $stable(vict_q)));

   // R8: single flush never sets a valid bit
   a_r8_flush_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 3'd4) |=> ((vld_q & ~$past(vld_q)) == '0));

   // R3: victim moves only on lock write, load or global flush
   a_r3_vict_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && (reg_addr == 3'd0 || reg_addr == 3'd3 || reg_addr == 3'd5))
      |=> $stable(vict_q));
endmodule

bind tlb_lockable tlb_lockable_chk #(.N(N)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .lk_req(lk_req), .lk_valid(lk_valid), .lk_hit(lk_hit),
   .vld_q(vld_q), .base_q(base_q), .vict_q(vict_q)
);

// File: tb/tb_tlb_lockable.sv
module tb_tlb_lockable;
   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [31:0] reg_wdata = 32'h0;
   logic [31:0] reg_rdata;
   logic        lk_req = 1'b0;
   logic [31:0] lk_va = 32'h0;
   logic        lk_valid, lk_hit;
   logic [31:0] lk_pa;
   logic [11:0] lk_attr;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   tlb_lockable #(.N(N)) dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_req(lk_req),
      .lk_va(lk_va), .lk_valid(lk_valid), .lk_hit(lk_hit),
      .lk_pa(lk_pa), .lk_attr(lk_attr)
   );

   // {va, hit, pa, attr}
   localparam logic [76:0] VECS [10] = '{
      {32'h0001_0ABC, 1'b1, 32'h8000_0ABC, 12'h012},
      {32'h0001_1000, 1'b0, 32'h0000_0000, 12'h000},
      {32'h0000_FFFF, 1'b0, 32'h0000_0000, 12'h000},
      {32'h0020_FFF0, 1'b1, 32'h9000_FFF0, 12'h034},
      {32'h0021_0000, 1'b0, 32'h0000_0000, 12'h000},
      {32'h030F_FFFC, 1'b1, 32'hA01F_FFFC, 12'h056},
      {32'h0310_0000, 1'b0, 32'h0000_0000, 12'h000},
      {32'h05FF_0004, 1'b1, 32'hB0FF_0004, 12'h078},
      {32'h0501_2345, 1'b1, 32'hB001_2345, 12'h078},
      {32'h0600_0000, 1'b0, 32'h0000_0000, 12'h000}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = 32'h0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic load(input logic [31:0] t, input logic [31:0] d);
      wr(3'd1, t); wr(3'd2, d); wr(3'd3, 32'h0);
   endtask

   task automatic look(input logic [31:0] va);
      lk_req = 1'b1; lk_va = va;
      @(negedge clk);
      lk_req = 1'b0;
   endtask

   task automatic look_chk(input string req, input logic [31:0] va, input logic h,
                           input logic [31:0] pa, input logic [11:0] at);
      look(va);
      chk(req, {31'h0, lk_valid}, 32'h1);
      chk(req, {31'h0, lk_hit}, {31'h0, h});
      if (h) begin
         chk(req, lk_pa, pa);
         chk(req, {20'h0, lk_attr}, {20'h0, at});
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(3'd0, v); chk("R1 lock", v, 32'h0);
      chk("R1 lk_valid idle", {31'h0, lk_valid}, 32'h0);
      look_chk("R1 miss", 32'h0001_0000, 1'b0, 32'h0, 12'h0);

      // R10 lock fields
      wr(3'd0, (32'd2 << 10) | (32'd5 << 4));
      rd(3'd0, v); chk("R10 lock readback", v, 32'h0000_0850);
      wr(3'd0, 32'h0);

      // R2/R3 loads into slots 0..4
      load(32'h0001_0000, 32'h8000_0012);
      load(32'h0020_0001, 32'h9000_0034);
      load(32'h0300_0002, 32'hA010_0056);
      load(32'h0500_0003, 32'hB000_0078);
      load(32'h0501_2000, 32'hC000_009A);
      rd(3'd0, v); chk("R3 victim after five loads", v, 32'h0000_0050);
      wr(3'd0, 32'd2 << 4);
      rd(3'd6, v); chk("R2 readback tag", v, 32'h0300_0006);
      rd(3'd7, v); chk("R2 readback data", v, 32'hA010_0056);

      // R5/R7 vector table
      for (int k = 0; k < 10; k++) begin
         look_chk((k == 8) ? "R7 lowest index" : "R5 page range",
                  VECS[k][76:45], VECS[k][44], VECS[k][43:12], VECS[k][11:0]);
      end

      // R6 one-cycle valid pulse
      look(32'h0001_0000);
      chk("R6 valid pulse", {31'h0, lk_valid}, 32'h1);
      @(negedge clk);
      chk("R6 valid drops", {31'h0, lk_valid}, 32'h0);

      // R3 wrap to base
      wr(3'd0, (32'd3 << 10) | (32'd7 << 4));
      load(32'h0700_0000, 32'hD000_0000);
      rd(3'd0, v); chk("R3 wrap to base", v, 32'h0000_0C30);
      look_chk("R3 slot7 entry", 32'h0700_0010, 1'b1, 32'hD000_0010, 12'h000);

      // R4 rejected load
      wr(3'd0, (32'd8 << 10) | (32'd1 << 4));
      load(32'h0900_0000, 32'hE000_0000);
      rd(3'd0, v); chk("R4 victim unchanged", v, 32'h0000_2010);
      rd(3'd6, v); chk("R4 slot1 tag kept", v, 32'h0020_0005);
      look_chk("R4 no new entry", 32'h0900_0000, 1'b0, 32'h0, 12'h0);

      // R8 single flush, base 2
      wr(3'd0, (32'd2 << 10) | (32'd2 << 4));
      wr(3'd4, 32'h0001_0ABC);
      look_chk("R8 pinned kept", 32'h0001_0ABC, 1'b1, 32'h8000_0ABC, 12'h012);
      wr(3'd4, 32'h0300_0004);
      look_chk("R8 unpinned flushed", 32'h0300_0004, 1'b0, 32'h0, 12'h0);
      wr(3'd4, 32'h0501_2345);
      look_chk("R8 both overlapping flushed", 32'h0501_2345, 1'b0, 32'h0, 12'h0);
      look_chk("R8 large flushed", 32'h0500_0000, 1'b0, 32'h0, 12'h0);
      look_chk("R8 other kept", 32'h0020_0100, 1'b1, 32'h9000_0100, 12'h034);

      // R9 global flush
      wr(3'd5, 32'h0);
      rd(3'd0, v); chk("R9 lock cleared", v, 32'h0);
      look_chk("R9 all invalid", 32'h0001_0ABC, 1'b0, 32'h0, 12'h0);
      look_chk("R9 slot7 invalid", 32'h0700_0010, 1'b0, 32'h0, 12'h0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule